// File: doc/BRIEF.md
# Flow-Control Update Watchdog

This block watches the flow-control traffic that arrives on a serial link and recovers the link if that traffic stops. While the link sits in one of its two active power states, L0 or L0s, and the block is enabled, a counter advances on each clock. Receiving an initialization or update flow-control DLLP clears the counter. A mode input widens this so that any received DLLP clears it. If the counter reaches its limit, the block emits one retrain request, and the link training state machine uses it to move the link into recovery.

The limit is given in clock cycles as cycles-per-microsecond times a microsecond budget, which defaults to 200. The request is a single-cycle pulse. After firing, the block stays silent until the link has left the active states and entered them again. Moving between L0 and L0s counts as staying active. The training state machine that acts on the request lies outside this block.

Top module: `fcu_watchdog`

## Requirements
- R1: The counter advances only on cycles where `enable`=1 and `link_state` is L0 (3'd3) or L0s (3'd4). `retrain_req` rises after exactly LIMIT = CYC_PER_US*TIMEOUT_US consecutive such cycles with no clearing event. Every other link state code (0,1,2,5,6,7) never produces a request.
- R2: A cycle in which the link is outside L0/L0s, or `enable`=0, resets the counter to zero. A fresh full LIMIT of counting cycles is then needed.
- R3: A strobe on `dllp_valid` with `dllp_kind` = 2'd1 (initialization FC) or 2'd2 (update FC) resets the counter to zero, whatever the mode.
- R4: With `any_dllp_mode`=1, a strobe of any `dllp_kind` (including 2'd0 and 2'd3) resets the counter. With `any_dllp_mode`=0, strobes of kinds 2'd0 and 2'd3 have no effect on the timing of the request.
- R5: `retrain_req` is high for exactly one cycle per expiry. After it fires, no further request comes until `link_state` has left L0/L0s and returned. A move from L0 to L0s does not re-arm the block.
- R6: When a clearing strobe lands in the same cycle in which the counter would expire, the strobe wins. No request is made, and a full LIMIT of further cycles is needed.
- R7: A synchronous active-high `rst` drives `retrain_req` low, zeroes the counter and re-arms the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 1 lets the timer run; 0 holds it at zero |
| link_state | input | 3 | Link training state code (3 = L0, 4 = L0s) |
| dllp_valid | input | 1 | One-cycle strobe: a DLLP was received |
| dllp_kind | input | 2 | Kind of received DLLP: 0 other, 1 init FC, 2 update FC, 3 other |
| any_dllp_mode | input | 1 | 1: any DLLP clears the timer |
| retrain_req | output | 1 | One-cycle request to retrain the link via recovery |

## Verification
Two functions can fall in the same cycle: the clearing of the timer by a received DLLP, and expiry of the timer. The bench provokes this by driving an update-FC strobe on exactly the last counting cycle of a full period. It judges the result by confirming that no pulse appears on that edge and that the first pulse comes a full LIMIT cycles later. The checker also requires that every clearing strobe is followed by a low request on the next edge.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  typedef enum logic [2:0] {
    LS_DETECT   = 3'd0,
    LS_POLLING  = 3'd1,
    LS_CONFIG   = 3'd2,
    LS_L0       = 3'd3,
    LS_L0S      = 3'd4,
    LS_RECOVERY = 3'd5,
    LS_L1       = 3'd6,
    LS_OTHER    = 3'd7
  } link_state_t;

  typedef enum logic [1:0] {
    DK_MISC  = 2'd0,
    DK_INIT  = 2'd1,
    DK_UPD   = 2'd2,
    DK_MISC2 = 2'd3
  } dllp_kind_t;

endpackage

// File: rtl/fcw_gate.sv
module fcw_gate
  import fcw_pkg::*;
(
  input  logic [2:0] link_state,
  input  logic       enable,
  output logic       link_active,
  output logic       count_ok
);
  always_comb begin
    link_active = (link_state == LS_L0) || (link_state == LS_L0S);
    count_ok    = link_active && enable;
  end
endmodule

// File: rtl/fcw_clear_sel.sv
module fcw_clear_sel
  import fcw_pkg::*;
(
  input  logic       dllp_valid,
  input  logic [1:0] dllp_kind,
  input  logic       any_dllp_mode,
  output logic       clr
);
  logic is_fc;
  always_comb begin
    is_fc = (dllp_kind == DK_INIT) || (dllp_kind == DK_UPD);
    clr   = dllp_valid && (is_fc || any_dllp_mode);
  end
endmodule

// File: rtl/fcw_arm.sv
module fcw_arm (
  input  logic clk,
  input  logic rst,
  input  logic link_active,
  input  logic fire,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst)               armed <= 1'b1;
    else if (!link_active) armed <= 1'b1;
    else if (fire)         armed <= 1'b0;
  end
endmodule

// File: rtl/fcw_timer.sv
module fcw_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic fire
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_comb fire = run && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || clr || fire) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fcu_watchdog.sv
module fcu_watchdog #(
  parameter int CYC_PER_US = 125,
  parameter int TIMEOUT_US = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [2:0] link_state,
  input  logic       dllp_valid,
  input  logic [1:0] dllp_kind,
  input  logic       any_dllp_mode,
  output logic       retrain_req
);
  localparam int LIMIT = CYC_PER_US * TIMEOUT_US;

  logic link_active, count_ok, clr, armed, fire;

  fcw_gate u_gate (
    .link_state (link_state),
    .enable     (enable),
    .link_active(link_active),
    .count_ok   (count_ok)
  );

  fcw_clear_sel u_clr (
    .dllp_valid   (dllp_valid),
    .dllp_kind    (dllp_kind),
    .any_dllp_mode(any_dllp_mode),
    .clr          (clr)
  );

  fcw_arm u_arm (
    .clk        (clk),
    .rst        (rst),
    .link_active(link_active),
    .fire       (fire),
    .armed      (armed)
  );

  fcw_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk (clk),
    .rst (rst),
    .run (count_ok && armed),
    .clr (clr),
    .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) retrain_req <= 1'b0;
    else     retrain_req <= fire;
  end
endmodule

// File: rtl/fcw_checker.sv
module fcw_checker (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic [2:0] link_state,
  input logic       dllp_valid,
  input logic [1:0] dllp_kind,
  input logic       any_dllp_mode,
  input logic       retrain_req
);
  logic act_in;
  logic fc_strobe;
  always_comb begin
    act_in    = enable && (link_state == 3'd3 || link_state == 3'd4);
    fc_strobe = dllp_valid && (dllp_kind == 2'd1 || dllp_kind == 2'd2);
  end

  p_active_only_r1: assert property (@(posedge clk) disable iff (rst)
    retrain_req |-> $past(act_in));

  p_idle_clears_r2: assert property (@(posedge clk) disable iff (rst)
    !act_in |=> !retrain_req);

  p_fc_clear_r3: assert property (@(posedge clk) disable iff (rst)
    fc_strobe |=> !retrain_req);

  p_any_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (dllp_valid && any_dllp_mode) |=> !retrain_req);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    retrain_req |=> !retrain_req);

  p_reset_quiet_r7: assert property (@(posedge clk)
    rst |=> !retrain_req);
endmodule

bind fcu_watchdog fcw_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .link_state   (link_state),
  .dllp_valid   (dllp_valid),
  .dllp_kind    (dllp_kind),
  .any_dllp_mode(any_dllp_mode),
  .retrain_req  (retrain_req)
);

// File: tb/sim_fcu_watchdog.sv
`timescale 1ns/1ps
module sim_fcu_watchdog;
  localparam int LIM = 200;  // CYC_PER_US=1, TIMEOUT_US=200

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, dllp_valid = 1'b0, any_dllp_mode = 1'b0;
  logic [2:0] link_state = 3'd0;
  logic [1:0] dllp_kind = 2'd0;
  logic retrain_req;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  fcu_watchdog #(.CYC_PER_US(1), .TIMEOUT_US(200)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .link_state(link_state),
    .dllp_valid(dllp_valid), .dllp_kind(dllp_kind),
    .any_dllp_mode(any_dllp_mode), .retrain_req(retrain_req)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  st;
    logic        en;
    logic        mode;
    logic [1:0]  kind;
    logic [15:0] strobe_at;  // 16'hFFFF = none
    logic [15:0] ncyc;
    logic [3:0]  exp_n;
    logic [15:0] exp_first;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{4'd1, 3'd3, 1'b1, 1'b0, 2'd0, 16'hFFFF, 16'd200, 4'd1, 16'd199}, // R1 L0 full
    '{4'd1, 3'd3, 1'b1, 1'b0, 2'd0, 16'hFFFF, 16'd199, 4'd0, 16'd0},   // R1 one short
    '{4'd1, 3'd4, 1'b1, 1'b0, 2'd0, 16'hFFFF, 16'd200, 4'd1, 16'd199}, // R1 L0s
    '{4'd1, 3'd5, 1'b1, 1'b0, 2'd0, 16'hFFFF, 16'd400, 4'd0, 16'd0},   // R1 recovery
    '{4'd1, 3'd6, 1'b1, 1'b0, 2'd0, 16'hFFFF, 16'd400, 4'd0, 16'd0},   // R1 L1
    '{4'd2, 3'd3, 1'b0, 1'b0, 2'd0, 16'hFFFF, 16'd400, 4'd0, 16'd0},   // R2 disabled
    '{4'd3, 3'd3, 1'b1, 1'b0, 2'd1, 16'd100,  16'd301, 4'd1, 16'd300}, // R3 init FC
    '{4'd3, 3'd3, 1'b1, 1'b0, 2'd2, 16'd150,  16'd351, 4'd1, 16'd350}, // R3 update FC
    '{4'd4, 3'd3, 1'b1, 1'b0, 2'd0, 16'd100,  16'd200, 4'd1, 16'd199}, // R4 ignored kind 0
    '{4'd4, 3'd3, 1'b1, 1'b1, 2'd0, 16'd100,  16'd301, 4'd1, 16'd300}, // R4 any mode kind 0
    '{4'd4, 3'd4, 1'b1, 1'b1, 2'd3, 16'd50,   16'd251, 4'd1, 16'd250}, // R4 any mode kind 3
    '{4'd6, 3'd3, 1'b1, 1'b0, 2'd2, 16'd199,  16'd400, 4'd1, 16'd399}, // R6 clear at expiry
    '{4'd5, 3'd3, 1'b1, 1'b0, 2'd0, 16'hFFFF, 16'd600, 4'd1, 16'd199}  // R5 one shot
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seg(input logic [2:0] st, input logic en, input logic md,
                         input logic [1:0] kd, input int strobe_at, input int ncyc,
                         output int npulse, output int first);
    npulse = 0; first = -1;
    for (int i = 0; i < ncyc; i++) begin
      link_state = st; enable = en; any_dllp_mode = md; dllp_kind = kd;
      dllp_valid = (i == strobe_at);
      @(posedge clk); #1;
      if (retrain_req) begin
        if (npulse == 0) first = i;
        npulse++;
      end
    end
    dllp_valid = 1'b0;
  endtask

  task automatic leave_link();
    int n, f;
    run_seg(3'd0, 1'b1, 1'b0, 2'd0, -1, 2, n, f);
  endtask

  task automatic expect_seg(input string req, input logic [2:0] st, input logic en,
                            input int ncyc, input int exp_n, input int exp_first);
    int n, f;
    run_seg(st, en, 1'b0, 2'd0, -1, ncyc, n, f);
    chk(n == exp_n, req, n, exp_n);
    if (exp_n > 0) chk(f == exp_first, req, f, exp_first);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, f;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(retrain_req == 1'b0, "R7 reset", retrain_req, 0);
    rst = 1'b0;

    foreach (TBL[k]) begin
      leave_link();
      run_seg(TBL[k].st, TBL[k].en, TBL[k].mode, TBL[k].kind,
              (TBL[k].strobe_at == 16'hFFFF) ? -1 : int'(TBL[k].strobe_at),
              int'(TBL[k].ncyc), n, f);
      checks++;
      if (n != int'(TBL[k].exp_n)) begin
        errors++;
        $display("FAIL R%0d vec %0d pulses: actual=%0d expected=%0d",
                 TBL[k].req, k, n, TBL[k].exp_n);
      end
      if (TBL[k].exp_n != 0) begin
        checks++;
        if (f != int'(TBL[k].exp_first)) begin
          errors++;
          $display("FAIL R%0d vec %0d first: actual=%0d expected=%0d",
                   TBL[k].req, k, f, TBL[k].exp_first);
        end
      end
    end

    // R7: mid-count reset restarts the period
    leave_link();
    expect_seg("R7 pre", 3'd3, 1'b1, 150, 0, 0);
    link_state = 3'd3; rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    expect_seg("R7 after reset", 3'd3, 1'b1, 200, 1, 199);

    // R5: L0 -> L0s does not re-arm; leaving does
    leave_link();
    expect_seg("R5 first", 3'd3, 1'b1, 210, 1, 199);
    expect_seg("R5 L0s no rearm", 3'd4, 1'b1, 300, 0, 0);
    leave_link();
    expect_seg("R5 rearmed", 3'd3, 1'b1, 200, 1, 199);

    // R2: leaving the active states clears the count
    leave_link();
    expect_seg("R2 pre", 3'd3, 1'b1, 150, 0, 0);
    expect_seg("R2 recovery", 3'd5, 1'b1, 10, 0, 0);
    expect_seg("R2 restart", 3'd3, 1'b1, 200, 1, 199);

    // R2: enable low clears the count
    leave_link();
    expect_seg("R2 en pre", 3'd3, 1'b1, 150, 0, 0);
    expect_seg("R2 en low", 3'd3, 1'b0, 5, 0, 0);
    expect_seg("R2 en restart", 3'd3, 1'b1, 200, 1, 199);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule